// File: doc/BRIEF.md
# Two-Stage Buffered Capture Channel

This block is one input capture channel backed by a second, buffering register. Each qualified edge strobe, while capture is enabled, records the value of the free-running timer in the capture register. An earlier value can move into the holding register so that software has time to collect it. Edge qualification and interrupt generation belong to neighbouring logic. This block only receives a one-cycle strobe that marks a valid transition.

The channel works in one of two modes. In latch mode, an explicit latch strobe copies the capture register into the holding register and overwrites whatever the holding register held. In queue mode, the two registers form a two-deep queue that captures push into. A protect option keeps unread data from being overwritten. With protect set, a capture that would destroy an unread value is discarded and a sticky lost flag is raised. Each register has its own full flag, which its read strobe clears.

Top module: `icb_capture_buf`

## Requirements
- R1: When `cap_en` and `edge_stb` are both high at a clock edge and the capture is accepted, `cap_q` holds the `timer_cnt` value from that edge and `cap_full` is 1 after the edge. When `cap_en` is low, `edge_stb` has no effect on any output.
- R2: With `no_ovw` = 0, a capture is always accepted. If the capture register is full (and not read in the same cycle), its old value moves to `hold_q` and `hold_full` becomes 1 in the same edge.
- R3: With `no_ovw` = 1 and `queue_mode` = 0, a capture that arrives while the capture register is full (and not read in that cycle) is dropped, and `cap_q` and `cap_full` keep their values.
- R4: With `no_ovw` = 1 and `queue_mode` = 1, a capture that arrives while the capture register is full is pushed if the holding register is empty: the old value moves to `hold_q` and the new timer value goes into `cap_q`. If both registers are full, the capture is dropped and both registers keep their values.
- R5: With `queue_mode` = 0 and no capture accepted in the same cycle, `latch_stb` copies `cap_q` into `hold_q`, sets `hold_full` to the prior value of `cap_full`, and clears `cap_full`. This applies whether or not the holding register was full. With `queue_mode` = 1, `latch_stb` has no effect.
- R6: `rd_cap` clears `cap_full` and `rd_hold` clears `hold_full`. A read leaves the data outputs unchanged.
- R7: A dropped capture sets `lost_flag`. `lost_flag` then stays 1 until reset.
- R8: A read and a capture in the same cycle: the read sees the old value on the output, the read frees the register for the protect decision, and the new value is stored with its full flag set.
- R9: While `rst_n` is low, `cap_q`, `hold_q`, `cap_full`, `hold_full` and `lost_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | TMR_W | Free-running timer value |
| cap_en | input | 1 | Capture enable |
| edge_stb | input | 1 | Qualified edge strobe, one cycle per transition |
| latch_stb | input | 1 | Latch strobe (latch mode only) |
| queue_mode | input | 1 | 1 = queue mode, 0 = latch mode |
| no_ovw | input | 1 | 1 = protect unread data |
| rd_cap | input | 1 | Read strobe for the capture register |
| rd_hold | input | 1 | Read strobe for the holding register |
| cap_q | output | TMR_W | Capture register |
| hold_q | output | TMR_W | Holding register |
| cap_full | output | 1 | Capture register holds unread data |
| hold_full | output | 1 | Holding register holds unread data |
| lost_flag | output | 1 | Sticky: a capture was dropped |

## Verification
The assertions assume that `timer_cnt` is stable around each edge and that the strobes are single-cycle synchronous pulses. They also assume that mode and protect inputs change only between events, although any cycle may mix capture, latch and read strobes. The stimulus drives every input at the falling clock edge. It holds each mode and protect combination for a long run and draws strobes with densities that keep both registers full often, so that drop, push and overwrite cases occur many times. Short directed runs cover same-cycle read with capture and latching into a full holding register.

// File: rtl/icb_pkg.sv
package icb_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_LOAD = 2'd1,
    CAP_PUSH = 2'd2,
    CAP_DROP = 2'd3
  } cap_act_e;

  // Decide what a capture event does, given which registers are free
  // after any same-cycle read.
  function automatic cap_act_e cap_decide(
    input logic evt,
    input logic queue_mode,
    input logic no_ovw,
    input logic cap_free,
    input logic hold_free
  );
    cap_act_e act;
    if (!evt)                      act = CAP_IDLE;
    else if (!no_ovw)              act = cap_free ? CAP_LOAD : CAP_PUSH;
    else if (cap_free)             act = CAP_LOAD;
    else if (queue_mode && hold_free) act = CAP_PUSH;
    else                           act = CAP_DROP;
    return act;
  endfunction

endpackage

// File: rtl/icb_slot.sv
module icb_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         ld_full,
  input  logic         rd,
  output logic [W-1:0] q,
  output logic         full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
    end else begin
      if (ld) q <= din;
      if (ld)      full <= ld_full;
      else if (rd) full <= 1'b0;
    end
  end

  // R6
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ld) |=> (!full && $stable(q)));

endmodule

// File: rtl/icb_ctrl.sv
module icb_ctrl
  import icb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic edge_stb,
  input  logic latch_stb,
  input  logic queue_mode,
  input  logic no_ovw,
  input  logic cap_free,
  input  logic hold_free,
  output logic accept,
  output logic push,
  output logic drop,
  output logic latch_go
);

  cap_act_e act;

  always_comb begin
    act      = cap_decide(cap_en && edge_stb, queue_mode, no_ovw, cap_free, hold_free);
    accept   = (act == CAP_LOAD) || (act == CAP_PUSH);
    push     = (act == CAP_PUSH);
    drop     = (act == CAP_DROP);
    latch_go = latch_stb && !queue_mode && !accept;
  end

  // R3
  latch_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && edge_stb && no_ovw && !queue_mode && !cap_free) |-> drop);

  // R4
  queue_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && edge_stb && no_ovw && queue_mode && !cap_free && hold_free) |-> push);

endmodule

// File: rtl/icb_capture_buf.sv
module icb_capture_buf #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] timer_cnt,
  input  logic             cap_en,
  input  logic             edge_stb,
  input  logic             latch_stb,
  input  logic             queue_mode,
  input  logic             no_ovw,
  input  logic             rd_cap,
  input  logic             rd_hold,
  output logic [TMR_W-1:0] cap_q,
  output logic [TMR_W-1:0] hold_q,
  output logic             cap_full,
  output logic             hold_full,
  output logic             lost_flag
);

  logic cap_free, hold_free;
  logic accept, push, drop, latch_go;
  logic             cap_ld, cap_ld_full, hold_ld, hold_ld_full;
  logic [TMR_W-1:0] cap_din;

  assign cap_free  = !cap_full  || rd_cap;
  assign hold_free = !hold_full || rd_hold;

  icb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .edge_stb(edge_stb), .latch_stb(latch_stb),
    .queue_mode(queue_mode), .no_ovw(no_ovw),
    .cap_free(cap_free), .hold_free(hold_free),
    .accept(accept), .push(push), .drop(drop), .latch_go(latch_go)
  );

  assign cap_ld       = accept || latch_go;
  assign cap_din      = accept ? timer_cnt : cap_q;
  assign cap_ld_full  = accept;
  assign hold_ld      = push || latch_go;
  assign hold_ld_full = push || !cap_free;

  icb_slot #(.W(TMR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ld(cap_ld), .din(cap_din),
    .ld_full(cap_ld_full), .rd(rd_cap), .q(cap_q), .full(cap_full)
  );

  icb_slot #(.W(TMR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld(hold_ld), .din(cap_q),
    .ld_full(hold_ld_full), .rd(rd_hold), .q(hold_q), .full(hold_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lost_flag <= 1'b0;
    else if (drop) lost_flag <= 1'b1;
  end

  // R1
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cap_full && cap_q == $past(timer_cnt)));

  // R2
  push_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (hold_full && hold_q == $past(cap_q)));

  // R7
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop || lost_flag) |=> lost_flag);

  // R3
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !latch_stb) |=> ($stable(cap_q) && cap_full));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!cap_full && !hold_full && !lost_flag && cap_q == '0 && hold_q == '0));

endmodule

// File: tb/tb_icb_capture_buf.sv
module tb_icb_capture_buf;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] timer_cnt = '0;
  logic cap_en = 0, edge_stb = 0, latch_stb = 0, queue_mode = 0, no_ovw = 0;
  logic rd_cap = 0, rd_hold = 0;
  logic [W-1:0] cap_q, hold_q;
  logic cap_full, hold_full, lost_flag;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  int  m_cap = 0, m_hold = 0;
  bit  m_cf = 0, m_hf = 0, m_lost = 0;

  always #10 clk = ~clk;

  icb_capture_buf #(.TMR_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .timer_cnt(timer_cnt), .cap_en(cap_en),
    .edge_stb(edge_stb), .latch_stb(latch_stb), .queue_mode(queue_mode),
    .no_ovw(no_ovw), .rd_cap(rd_cap), .rd_hold(rd_hold),
    .cap_q(cap_q), .hold_q(hold_q), .cap_full(cap_full),
    .hold_full(hold_full), .lost_flag(lost_flag)
  );

  task automatic check_one(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check_one("R1/R8 cap_q",     int'(cap_q),     m_cap);
    check_one("R2/R5 hold_q",    int'(hold_q),    m_hold);
    check_one("R6 cap_full",     int'(cap_full),  int'(m_cf));
    check_one("R4/R6 hold_full", int'(hold_full), int'(m_hf));
    check_one("R7 lost_flag",    int'(lost_flag), int'(m_lost));
  endtask

  // Reference step, written from the requirements: state after next edge.
  task automatic model_step();
    bit cfree, hfree, took, moved;
    int nc, nh;
    bit ncf, nhf;
    cfree = !m_cf || rd_cap;
    hfree = !m_hf || rd_hold;
    nc = m_cap; nh = m_hold;
    ncf = m_cf && !rd_cap;
    nhf = m_hf && !rd_hold;
    took = 0; moved = 0;
    if (cap_en && edge_stb) begin
      if (no_ovw == 0) begin
        took = 1; moved = !cfree;
      end else if (cfree) begin
        took = 1;
      end else if (queue_mode && hfree) begin
        took = 1; moved = 1;
      end else begin
        m_lost = 1;
      end
    end
    if (moved) begin nh = m_cap; nhf = 1; end
    if (took)  begin nc = int'(timer_cnt); ncf = 1; end
    if (latch_stb && !queue_mode && !took) begin
      nh = m_cap; nhf = !cfree; ncf = 0;
    end
    m_cap = nc; m_hold = nh; m_cf = ncf; m_hf = nhf;
  endtask

  // Apply one cycle of inputs, then check at the following falling edge.
  task automatic cyc(input bit en, input bit stb, input bit lat,
                     input bit rc, input bit rh);
    cap_en = en; edge_stb = stb; latch_stb = lat; rd_cap = rc; rd_hold = rh;
    model_step();
    @(negedge clk);
    timer_cnt = timer_cnt + 16'd7;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    timer_cnt = 16'd100;
    repeat (3) @(negedge clk);
    // R9: reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R1: capture, and enable gating
    cyc(1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    // R2: overwrite pushes into hold
    cyc(1, 1, 0, 0, 0);
    // R5: latch into a full hold overwrites it
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    // R6: reads clear flags
    cyc(0, 0, 0, 1, 1);
    // R3: protect in latch mode drops, R7 sticky
    no_ovw = 1;
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R8: read and capture together
    cyc(1, 1, 0, 1, 0);
    // R4: queue mode push then drop, latch ignored
    queue_mode = 1;
    cyc(0, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 1);

    // R9: reset again mid-run
    rst_n = 1'b0;
    m_cap = 0; m_hold = 0; m_cf = 0; m_hf = 0; m_lost = 0;
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;

    // random runs over all mode/protect combinations
    for (int mode = 0; mode < 4; mode++) begin
      queue_mode = mode[0];
      no_ovw     = mode[1];
      for (int i = 0; i < 1500; i++) begin
        cyc(($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
            ($urandom % 5) == 0, ($urandom % 5) == 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule